// File: doc/BRIEF.md
# LCD Common Waveform Timing Generator

This block turns a stream of oscillator ticks into frame timing and common-electrode drive codes for a two-common LCD panel. It runs on one system clock. A pin picks which tick stream drives it: the one from the on-die oscillator or the one from an external clock. A prescaler divides the chosen ticks by 64 or 128. Each prescaler period is one sub-frame. A 2-bit sub-frame counter then produces the alternation that keeps the panel free of DC bias.

In static mode, both commons carry the same two-level square wave. In half-duty mode, each sub-frame cycle has four steps. Each common is driven high or low only during its own phase, and it rests at the mid level during the other phase. The polarity reverses on every pass.

The block gives the segment data path the current phase and polarity. It also cooperates with other devices through a sync line. A master drives the sync line while in half-duty mode. A slave restarts its prescaler and counter on each rising edge of the incoming sync. The analog oscillator, the mid-level generator and the output drivers are not part of this block. The common outputs are encoded logic values.

Top module: `lcd_com_timing`

## Requirements
- R1: While reset is high, and on the first cycle after it, the prescaler count and sub-frame step are zero. In static mode this means both commons show LOW (00), polarity is 0, phase_b is 0 and sync_out is 0.
- R2: When src_ext is 1, only ext_tick advances the prescaler; when it is 0, only int_tick does. The tick that is not selected has no effect on any output.
- R3: The sub-frame step advances by one, modulo 4, on the selected tick that completes 64 ticks (div_long=0) or 128 ticks (div_long=1). If div_long drops to 0 while the count is already at or past 63, the next selected tick ends the period.
- R4: In static mode (duty_mode=0), polarity equals step bit 0 and phase_b is 0. Both commons are equal: HIGH (10) when polarity is 1 and LOW (00) when it is 0. Neither common ever shows MID (01).
- R5: In half-duty mode (duty_mode=1), phase_b equals step bit 0 (0 = phase A, 1 = phase B) and polarity equals step bit 1. The step order is A+0, B+0, A+1, B+1.
- R6: In half-duty mode, com_a is active in phase A and com_b in phase B. The active common shows HIGH (10) when polarity is 1 and LOW (00) when it is 0. The inactive common shows MID (01). The code 11 never appears.
- R7: sync_out is 1 exactly when duty_mode=1, slave_mode=0 and the step is 0. Otherwise it is 0.
- R8: In slave mode, a rising edge of sync_in clears the prescaler count and the step to zero at that clock edge. This takes priority over a period-ending tick in the same cycle.
- R9: In master mode (slave_mode=0), sync_in has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ext | input | 1 | 1 selects ext_tick, 0 selects int_tick |
| int_tick | input | 1 | One-cycle tick from the on-die oscillator |
| ext_tick | input | 1 | One-cycle tick from the external clock |
| div_long | input | 1 | Prescaler length: 1 = 128 ticks, 0 = 64 ticks |
| duty_mode | input | 1 | 1 = half-duty, 0 = static |
| slave_mode | input | 1 | 1 = follow sync_in, 0 = master |
| sync_in | input | 1 | Sync from the master device |
| com_a | output | 2 | Common A code (00 low, 01 mid, 10 high) |
| com_b | output | 2 | Common B code (00 low, 01 mid, 10 high) |
| phase_b | output | 1 | 1 while phase B is active |
| polarity | output | 1 | Current drive polarity |
| sync_out | output | 1 | Sync pulse to slave devices |

## Verification
In slave mode, a sync realignment and a period-ending prescaler tick can arrive on the same clock edge. The first would clear the counters and the second would advance the step. To provoke this, the bench keeps ticks running every cycle and watches its own model count. When the count sits one tick short of the period, the bench raises sync_in for the next edge. The result is judged by requiring that the step then reads zero (polarity 0, phase A) rather than the advanced value, and that the next full period is timed from that edge.

// File: rtl/lcdcom_pkg.sv
package lcdcom_pkg;

    localparam int COM_LINES = 2;

    typedef enum logic [1:0] {
        COM_LOW  = 2'b00,
        COM_MID  = 2'b01,
        COM_HIGH = 2'b10
    } com_code_e;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   pol;
    } subframe_t;

    // Active-level code for a common given the drive polarity.
    function automatic com_code_e drive_level(input logic pol);
        return pol ? COM_HIGH : COM_LOW;
    endfunction

    // Map the step counter to phase and polarity for the selected mode.
    function automatic subframe_t decode_step(input logic [1:0] step, input logic duty);
        subframe_t sf;
        if (duty) begin
            sf.phase = phase_e'(step[0]);
            sf.pol   = step[1];
        end else begin
            sf.phase = PH_A;
            sf.pol   = step[0];
        end
        return sf;
    endfunction

endpackage

// File: rtl/lcdcom_prescaler.sv
module lcdcom_prescaler #(
    parameter int DIV_SHORT = 64,
    parameter int DIV_LONG  = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic src_ext,
    input  logic int_tick,
    input  logic ext_tick,
    input  logic div_long,
    input  logic clear,
    output logic stage_done
);
    localparam int CW = $clog2(DIV_LONG);
    localparam logic [CW-1:0] LIM_SHORT = CW'(DIV_SHORT - 1);
    localparam logic [CW-1:0] LIM_LONG  = CW'(DIV_LONG - 1);

    logic [CW-1:0] count;
    logic [CW-1:0] limit;
    logic          tick;
    logic          at_end;

    assign tick       = src_ext ? ext_tick : int_tick;
    assign limit      = div_long ? LIM_LONG : LIM_SHORT;
    assign at_end     = (count >= limit);
    assign stage_done = tick && at_end && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (tick) begin
            count <= at_end ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/lcdcom_sequencer.sv
module lcdcom_sequencer (
    input  logic       clk,
    input  logic       rst,
    input  logic       slave_mode,
    input  logic       sync_in,
    input  logic       advance,
    output logic [1:0] step,
    output logic       realign
);
    logic sync_prev;

    assign realign = slave_mode && sync_in && !sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev <= 1'b1;
            step      <= 2'd0;
        end else begin
            sync_prev <= sync_in;
            if (realign) begin
                step <= 2'd0;
            end else if (advance) begin
                step <= step + 2'd1;
            end
        end
    end
endmodule

// File: rtl/lcdcom_encoder.sv
module lcdcom_encoder
    import lcdcom_pkg::*;
(
    input  logic                        duty_mode,
    input  logic                        slave_mode,
    input  logic [1:0]                  step,
    output logic [COM_LINES-1:0][1:0]   com_codes,
    output logic                        phase_b,
    output logic                        polarity,
    output logic                        sync_out
);
    subframe_t sf;

    assign sf       = decode_step(step, duty_mode);
    assign phase_b  = (sf.phase == PH_B);
    assign polarity = sf.pol;
    assign sync_out = duty_mode && !slave_mode && (step == 2'd0);

    for (genvar i = 0; i < COM_LINES; i++) begin : g_com
        assign com_codes[i] = !duty_mode ? drive_level(sf.pol)
                            : (sf.phase == phase_e'(i)) ? drive_level(sf.pol)
                            : COM_MID;
    end
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing #(
    parameter int DIV_SHORT = 64,
    parameter int DIV_LONG  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_ext,
    input  logic       int_tick,
    input  logic       ext_tick,
    input  logic       div_long,
    input  logic       duty_mode,
    input  logic       slave_mode,
    input  logic       sync_in,
    output logic [1:0] com_a,
    output logic [1:0] com_b,
    output logic       phase_b,
    output logic       polarity,
    output logic       sync_out
);
    import lcdcom_pkg::*;

    logic                       stage_done;
    logic                       realign;
    logic [1:0]                 step;
    logic [COM_LINES-1:0][1:0]  com_codes;

    lcdcom_prescaler #(
        .DIV_SHORT (DIV_SHORT),
        .DIV_LONG  (DIV_LONG)
    ) u_pre (
        .clk        (clk),
        .rst        (rst),
        .src_ext    (src_ext),
        .int_tick   (int_tick),
        .ext_tick   (ext_tick),
        .div_long   (div_long),
        .clear      (realign),
        .stage_done (stage_done)
    );

    lcdcom_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .slave_mode (slave_mode),
        .sync_in    (sync_in),
        .advance    (stage_done),
        .step       (step),
        .realign    (realign)
    );

    lcdcom_encoder u_enc (
        .duty_mode  (duty_mode),
        .slave_mode (slave_mode),
        .step       (step),
        .com_codes  (com_codes),
        .phase_b    (phase_b),
        .polarity   (polarity),
        .sync_out   (sync_out)
    );

    assign com_a = com_codes[0];
    assign com_b = com_codes[1];
endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       src_ext,
    input logic       int_tick,
    input logic       ext_tick,
    input logic       duty_mode,
    input logic       slave_mode,
    input logic       sync_in,
    input logic [1:0] com_a,
    input logic [1:0] com_b,
    input logic       phase_b,
    input logic       polarity,
    input logic       sync_out
);
    assert_code_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (com_a != 2'b11) && (com_b != 2'b11));

    assert_static_equal_R4: assert property (@(posedge clk) disable iff (rst)
        !duty_mode |-> (com_a == com_b) && (com_a != 2'b01) && !phase_b);

    assert_one_mid_R6: assert property (@(posedge clk) disable iff (rst)
        duty_mode |-> ((com_a == 2'b01) != (com_b == 2'b01)));

    assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (slave_mode || !duty_mode) |-> !sync_out);

    assert_realign_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && $rose(sync_in) && !$past(rst)) |=> (!polarity && !phase_b));

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!(src_ext ? ext_tick : int_tick) && !(slave_mode && sync_in))
        |=> (duty_mode != $past(duty_mode)) || ($stable(polarity) && $stable(phase_b)));
endmodule

bind lcd_com_timing lcd_com_timing_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_ext    (src_ext),
    .int_tick   (int_tick),
    .ext_tick   (ext_tick),
    .duty_mode  (duty_mode),
    .slave_mode (slave_mode),
    .sync_in    (sync_in),
    .com_a      (com_a),
    .com_b      (com_b),
    .phase_b    (phase_b),
    .polarity   (polarity),
    .sync_out   (sync_out)
);

// File: tb/lcd_com_timing_test.sv
`timescale 1ns/1ps
module lcd_com_timing_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_ext = 1'b0, int_tick = 1'b0, ext_tick = 1'b0;
    logic       div_long = 1'b0, duty_mode = 1'b0, slave_mode = 1'b0, sync_in = 1'b0;
    logic [1:0] com_a, com_b;
    logic       phase_b, polarity, sync_out;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_div = 0, m_step = 0, m_prev = 1;
    // stimulus settings
    int tick_every = 1;
    int cyc = 0;
    bit sync_random = 0;
    bit hold_sync = 0;

    always #4 clk = ~clk;

    lcd_com_timing uut (
        .clk(clk), .rst(rst), .src_ext(src_ext), .int_tick(int_tick), .ext_tick(ext_tick),
        .div_long(div_long), .duty_mode(duty_mode), .slave_mode(slave_mode), .sync_in(sync_in),
        .com_a(com_a), .com_b(com_b), .phase_b(phase_b), .polarity(polarity), .sync_out(sync_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_edge();
        int lim;
        bit tk, rise;
        lim = div_long ? 128 : 64;
        if (rst) begin
            m_div = 0; m_step = 0; m_prev = 1;
        end else begin
            tk   = src_ext ? ext_tick : int_tick;
            rise = slave_mode && sync_in && (m_prev == 0);
            m_prev = sync_in;
            if (rise) begin
                m_div = 0; m_step = 0;
            end else if (tk) begin
                if (m_div >= lim - 1) begin
                    m_div = 0; m_step = (m_step + 1) % 4;
                end else m_div++;
            end
        end
    endtask

    task automatic compare(input string tag);
        int pol, ph, ea, eb, es;
        pol = duty_mode ? m_step / 2 : m_step % 2;
        ph  = duty_mode ? m_step % 2 : 0;
        if (!duty_mode) begin
            ea = pol ? 2 : 0; eb = ea;
        end else begin
            ea = (ph == 0) ? (pol ? 2 : 0) : 1;
            eb = (ph == 1) ? (pol ? 2 : 0) : 1;
        end
        es = (duty_mode && !slave_mode && m_step == 0) ? 1 : 0;
        check({tag, " com_a"}, com_a, ea);
        check({tag, " com_b"}, com_b, eb);
        check(duty_mode ? "R5 phase" : {tag, " phase"}, phase_b, ph);
        check(duty_mode ? "R5 polarity" : {tag, " polarity"}, polarity, pol);
        check("R7 sync_out", sync_out, es);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic one_cycle(input string tag);
        bit sel;
        sel = ((cyc % tick_every) == 0);
        if (src_ext) begin
            ext_tick = sel; int_tick = $urandom_range(0, 1);
        end else begin
            int_tick = sel; ext_tick = $urandom_range(0, 1);
        end
        if (sync_random && !hold_sync) sync_in = ($urandom_range(0, 40) == 0) ? ~sync_in : sync_in;
        @(posedge clk);
        model_edge();
        cyc++;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) one_cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) begin
            @(posedge clk); model_edge(); @(negedge clk);
        end
        // R1: reset state
        check("R1 com_a", com_a, 0);
        check("R1 com_b", com_b, 0);
        check("R1 polarity", polarity, 0);
        check("R1 phase", phase_b, 0);
        check("R1 sync_out", sync_out, 0);
        rst = 1'b0;
        one_cycle("R1");

        // static, internal ticks, 64 then 128
        run(700, "R4");
        div_long = 1'b1;
        run(700, "R3");

        // half-duty master
        div_long = 1'b0; duty_mode = 1'b1;
        run(700, "R6");

        // external source with sparse ticks, internal stream is noise
        src_ext = 1'b1; tick_every = 3;
        run(1600, "R2");

        // shorten the period while the count is past the short limit
        src_ext = 1'b0; tick_every = 1; div_long = 1'b1;
        while (m_div != 100) one_cycle("R3");
        div_long = 1'b0;
        run(300, "R3");

        // master ignores sync activity
        sync_random = 1;
        run(1500, "R9");

        // slave with random sync edges
        slave_mode = 1'b1;
        run(1500, "R8");

        // forced coincidence: sync edge on the period-ending tick
        sync_random = 0; hold_sync = 1;
        for (int k = 0; k < 4; k++) begin
            sync_in = 1'b0;
            run(3, "R8");
            while (m_div != 63) one_cycle("R8");
            sync_in = 1'b1;
            one_cycle("R8");
            check("R8 step cleared polarity", polarity, 0);
            check("R8 step cleared phase", phase_b, 0);
            run(70, "R8");
        end

        // static slave
        duty_mode = 1'b0; sync_random = 1; hold_sync = 0;
        run(800, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule